// File: doc/BRIEF.md
# LIN Slave Header Synchroniser

This block sits on the receive line of a LIN slave node, downstream of the bus transceiver. It looks for the long dominant pulse that opens every frame header, checks the recessive gap that follows it, and then times the 0x55 synchronisation byte to recover the bit period the master is using. A free-running timer, clocked by the fixed reference clock, provides the edge timestamps. All lengths are differences between those timestamps, and the timer is allowed to wrap.

After a clean header the block reports the recovered bit period in reference-clock ticks together with a one-cycle `sync_ok` pulse. A header that starts correctly but then fails a length or rate check gives a one-cycle `sync_error` pulse, and the block goes back to waiting for the next break. Short dominant pulses, such as ordinary data bytes, are dropped without any report. A separate watch raises a no-bus-activity flag when no acceptable break has been seen for a long, configurable number of bit times.

Top module: `lin_sync_recover`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sync_ok`, `sync_error`, `no_bus_activity` and `bit_period` are all 0.
- R2: `rx_in` is 0 when the bus is dominant and 1 when it is recessive. A dominant pulse is a break when its length, counted in clock cycles from the cycle `rx_in` is first sampled 0 to the cycle it is first sampled 1, is at least BRK_BITS×NOM_BIT_TICKS. A shorter pulse sends the block back to idle and raises neither `sync_error` nor `sync_ok`.
- R3: If a falling edge comes less than NOM_BIT_TICKS cycles after the break's rising edge, `sync_error` pulses and that falling edge becomes the start of a new break measurement.
- R4: If the recessive gap after a break passes DELIM_MAX_BITS×NOM_BIT_TICKS cycles with no falling edge, `sync_error` pulses and the block returns to idle.
- R5: The first falling edge after a valid gap is the reference. On the fourth falling edge after it, the span S between the two edges is taken, and `bit_period` becomes S shifted right by 3 (S covers eight bits). `sync_ok` pulses in the cycle after that edge is sampled. `bit_period` changes only together with `sync_ok`.
- R6: If S is below 8×NOM_BIT_TICKS×(100−TOL_PCT)/100 (integer division), `sync_error` pulses, `sync_ok` stays low and `bit_period` keeps its old value.
- R7: If more than 8×NOM_BIT_TICKS×(100+TOL_PCT)/100 cycles pass after the reference edge without the fourth falling edge, `sync_error` pulses and the block returns to idle.
- R8: `no_bus_activity` goes to 1 once IDLE_BITS×NOM_BIT_TICKS clock edges have passed since reset or since the last accepted break end. It goes back to 0 at an accepted break end. If the two fall on the same edge, the clear wins.
- R9: `sync_ok` and `sync_error` are single-cycle pulses and are never high together.
- R10: A break longer than the timer's wrap-around period is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick of every time measurement |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_in | input | 1 | Bus receive level, already synchronised (0 = dominant) |
| sync_ok | output | 1 | One-cycle pulse: header accepted, `bit_period` updated |
| sync_error | output | 1 | One-cycle pulse: header rejected after a valid break |
| bit_period | output | TIMER_W−3 | Recovered bit period in clock ticks |
| no_bus_activity | output | 1 | High while no break has been accepted for the idle window |

## Verification
Two functions can hit the same clock edge: the acceptance of a break end and the expiry of the no-activity window, which pull `no_bus_activity` in opposite directions. The bench uses its own count of quiet edges to time a break so that its rising edge is sampled on exactly the edge where the window would run out. It then requires that the flag never rises during that stretch and that the header after it still completes. The behavioural model, which works on integer cycle stamps, also checks every other cycle of the run, including one break long enough to wrap the timer.

// File: rtl/lsr_pkg.sv
// Shared types for the LIN slave header synchroniser.
package lsr_pkg;
    // Header tracking phases: waiting, dominant break, recessive gap, sync byte
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BREAK = 2'd1,
        ST_GAP   = 2'd2,
        ST_SYNC  = 2'd3
    } hdr_state_e;
endpackage

// File: rtl/lsr_edge_timer.sv
// Free-running timestamp counter plus edge detection on the receive line.
// Assumes rx is already synchronised to clk. The line idles recessive (1).
module lsr_edge_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx,
    output logic               fall,
    output logic               rise,
    output logic [TIMER_W-1:0] now
);
    logic rx_q;

    // Hold the previous line level and advance the timestamp every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b1;
            now  <= '0;
        end else begin
            rx_q <= rx;
            now  <= now + 1'b1;
        end
    end

    assign fall = rx_q & ~rx;
    assign rise = ~rx_q & rx;
endmodule

// File: rtl/lsr_hdr_fsm.sv
// Header sequencer: checks the break and the gap, times four sync-byte bits
// pairs, and reports the recovered period. All limits are in clock ticks and
// must lie below 2**TIMER_W. Break length alone may exceed the timer range.
module lsr_hdr_fsm
    import lsr_pkg::*;
#(
    parameter int TIMER_W   = 16,
    parameter int BRK_TICKS = 4587,
    parameter int GAP_MIN   = 417,
    parameter int GAP_MAX   = 6672,
    parameter int SPAN_LO   = 2835,
    parameter int SPAN_HI   = 3836
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall,
    input  logic               rise,
    input  logic [TIMER_W-1:0] now,
    output logic               brk_accept,
    output logic               sync_ok,
    output logic               sync_error,
    output logic [TIMER_W-4:0] period
);
    localparam logic [TIMER_W-1:0] BRK_L  = TIMER_W'(BRK_TICKS);
    localparam logic [TIMER_W-1:0] GAP_L  = TIMER_W'(GAP_MIN);
    localparam logic [TIMER_W-1:0] GAP_H  = TIMER_W'(GAP_MAX);
    localparam logic [TIMER_W-1:0] SPAN_L = TIMER_W'(SPAN_LO);
    localparam logic [TIMER_W-1:0] SPAN_H = TIMER_W'(SPAN_HI);

    hdr_state_e         state, state_n;
    logic [TIMER_W-1:0] cap, cap_n, elapsed;
    logic [1:0]         nfall, nfall_n;
    logic               long_q, long_n;
    logic               ok_n, err_n;
    logic [TIMER_W-4:0] per_n;

    // Wrap-around distance from the last captured edge
    assign elapsed = now - cap;

    // Next-state decision for every header phase
    always_comb begin
        state_n    = state;
        cap_n      = cap;
        nfall_n    = nfall;
        long_n     = long_q;
        ok_n       = 1'b0;
        err_n      = 1'b0;
        per_n      = period;
        brk_accept = 1'b0;
        case (state)
            ST_IDLE: begin
                if (fall) begin
                    cap_n   = now;
                    long_n  = 1'b0;
                    state_n = ST_BREAK;
                end
            end
            ST_BREAK: begin
                if (rise) begin
                    if (long_q || elapsed >= BRK_L) begin
                        brk_accept = 1'b1;
                        cap_n      = now;
                        state_n    = ST_GAP;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end else if (elapsed >= BRK_L) begin
                    long_n = 1'b1;
                end
            end
            ST_GAP: begin
                if (fall) begin
                    cap_n = now;
                    if (elapsed < GAP_L) begin
                        err_n   = 1'b1;
                        long_n  = 1'b0;
                        state_n = ST_BREAK;
                    end else begin
                        nfall_n = '0;
                        state_n = ST_SYNC;
                    end
                end else if (elapsed > GAP_H) begin
                    err_n   = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            ST_SYNC: begin
                if (fall) begin
                    if (nfall == 2'd3) begin
                        if (elapsed >= SPAN_L && elapsed <= SPAN_H) begin
                            ok_n  = 1'b1;
                            per_n = elapsed[TIMER_W-1:3];
                        end else begin
                            err_n = 1'b1;
                        end
                        state_n = ST_IDLE;
                    end else begin
                        nfall_n = nfall + 1'b1;
                    end
                end else if (elapsed > SPAN_H) begin
                    err_n   = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Register phase, captures and the reported results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cap        <= '0;
            nfall      <= '0;
            long_q     <= 1'b0;
            sync_ok    <= 1'b0;
            sync_error <= 1'b0;
            period     <= '0;
        end else begin
            state      <= state_n;
            cap        <= cap_n;
            nfall      <= nfall_n;
            long_q     <= long_n;
            sync_ok    <= ok_n;
            sync_error <= err_n;
            period     <= per_n;
        end
    end
endmodule

// File: rtl/lsr_idle_watch.sv
// No-activity watch: counts clock edges since reset or the last accepted
// break and raises a flag at the limit. A clear on the same edge wins.
module lsr_idle_watch #(
    parameter int IDLE_TICKS = 10425000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic nba
);
    localparam int              CW   = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0]   LAST = CW'(IDLE_TICKS - 1);

    logic [CW-1:0] cnt;

    // Count quiet edges and latch the flag once the window is used up
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            nba <= 1'b0;
        end else if (!nba) begin
            if (cnt == LAST) nba <= 1'b1;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lin_sync_recover.sv
// Top of the LIN slave header synchroniser. Converts bit-based limits into
// clock-tick limits and wires the timer, the sequencer and the idle watch.
// Assumes rx_in is synchronised and NOM_BIT_TICKS matches the nominal rate.
module lin_sync_recover #(
    parameter int TIMER_W        = 16,
    parameter int NOM_BIT_TICKS  = 417,
    parameter int BRK_BITS       = 11,
    parameter int DELIM_MAX_BITS = 16,
    parameter int TOL_PCT        = 15,
    parameter int IDLE_BITS      = 25000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_in,
    output logic               sync_ok,
    output logic               sync_error,
    output logic [TIMER_W-4:0] bit_period,
    output logic               no_bus_activity
);
    localparam int SPAN_NOM   = 8 * NOM_BIT_TICKS;
    localparam int BRK_TICKS  = BRK_BITS * NOM_BIT_TICKS;
    localparam int GAP_MAX    = DELIM_MAX_BITS * NOM_BIT_TICKS;
    localparam int SPAN_LO    = SPAN_NOM * (100 - TOL_PCT) / 100;
    localparam int SPAN_HI    = SPAN_NOM * (100 + TOL_PCT) / 100;
    localparam int IDLE_TICKS = IDLE_BITS * NOM_BIT_TICKS;

    logic               fall, rise, brk_accept;
    logic [TIMER_W-1:0] now;

    lsr_edge_timer #(.TIMER_W(TIMER_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .rx(rx_in),
        .fall(fall), .rise(rise), .now(now)
    );

    lsr_hdr_fsm #(
        .TIMER_W(TIMER_W), .BRK_TICKS(BRK_TICKS), .GAP_MIN(NOM_BIT_TICKS),
        .GAP_MAX(GAP_MAX), .SPAN_LO(SPAN_LO), .SPAN_HI(SPAN_HI)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise), .now(now),
        .brk_accept(brk_accept), .sync_ok(sync_ok), .sync_error(sync_error),
        .period(bit_period)
    );

    lsr_idle_watch #(.IDLE_TICKS(IDLE_TICKS)) i_idle (
        .clk(clk), .rst_n(rst_n), .clear(brk_accept), .nba(no_bus_activity)
    );
endmodule

// File: rtl/lsr_checker.sv
// Temporal checks on the synchroniser's ports, attached by bind below.
module lsr_checker #(
    parameter int P_W = 13
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rx,
    input logic           sync_ok,
    input logic           sync_error,
    input logic           nba,
    input logic [P_W-1:0] period
);
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_ok && sync_error));
    p_ok_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |=> !sync_ok);
    p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_error |=> !sync_error);
    p_period_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |-> $stable(period));
    p_ok_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |-> (!$past(rx) && $past(rx, 2)));
    p_nba_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nba) |-> ($past(rx) && !$past(rx, 2)));
endmodule

bind lin_sync_recover lsr_checker #(.P_W(TIMER_W - 3)) i_lsr_checker (
    .clk(clk), .rst_n(rst_n), .rx(rx_in), .sync_ok(sync_ok),
    .sync_error(sync_error), .nba(no_bus_activity), .period(bit_period)
);

// File: tb/test_lin_sync_recover.sv
module test_lin_sync_recover;
    localparam int CLK_PERIOD = 10;
    localparam int NOM    = 16;
    localparam int IDLE_B = 200;
    localparam int BRK_T  = 11 * NOM;
    localparam int GMAX_T = 16 * NOM;
    localparam int SLO    = 8 * NOM * 85 / 100;
    localparam int SHI    = 8 * NOM * 115 / 100;
    localparam int IDLE_T = IDLE_B * NOM;
    localparam logic [7:0] SYNC_PAT = 8'h55;

    logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1;
    logic sync_ok, sync_error, no_bus_activity;
    logic [12:0] bit_period;

    int n_chk = 0, n_fail = 0;
    bit live = 0, done = 0;
    int cnt_ok = 0, cnt_err = 0, cnt_nba = 0;

    // behavioural model state (integer cycle stamps)
    int cyc = 0, t0 = 0, m_state = 0, nf = 0, quiet = 0;
    int m_ok = 0, m_err = 0, m_per = 0, m_nba = 0;
    bit m_prev = 1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lin_sync_recover #(.TIMER_W(16), .NOM_BIT_TICKS(NOM), .BRK_BITS(11),
        .DELIM_MAX_BITS(16), .TOL_PCT(15), .IDLE_BITS(IDLE_B)) i_lin_sync_recover (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .sync_ok(sync_ok),
        .sync_error(sync_error), .bit_period(bit_period),
        .no_bus_activity(no_bus_activity));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_prev = 1; m_ok = 0; m_err = 0; m_per = 0;
            quiet = 0; m_nba = 0; cyc = 0;
        end else begin
            bit f, r, acc;
            cyc++; m_ok = 0; m_err = 0; acc = 0;
            f = m_prev && !rx_in;
            r = !m_prev && rx_in;
            case (m_state)
                0: if (f) begin t0 = cyc; m_state = 1; end
                1: if (r) begin
                       if (cyc - t0 >= BRK_T) begin acc = 1; t0 = cyc; m_state = 2; end
                       else m_state = 0;
                   end
                2: if (f) begin
                       if (cyc - t0 < NOM) begin m_err = 1; t0 = cyc; m_state = 1; end
                       else begin t0 = cyc; nf = 0; m_state = 3; end
                   end else if (cyc - t0 > GMAX_T) begin m_err = 1; m_state = 0; end
                default: if (f) begin
                       nf++;
                       if (nf == 4) begin
                           if (cyc - t0 >= SLO && cyc - t0 <= SHI) begin
                               m_ok = 1; m_per = (cyc - t0) / 8;
                           end else m_err = 1;
                           m_state = 0;
                       end
                   end else if (cyc - t0 > SHI) begin m_err = 1; m_state = 0; end
            endcase
            m_prev = rx_in;
            quiet = acc ? 0 : quiet + 1;
            m_nba = (quiet >= IDLE_T) ? 1 : 0;
        end
    end

    // compare the design with the model and tally pulses on every falling edge
    always @(negedge clk) begin
        if (rst_n && live) begin
            chk("R5 sync_ok", int'(sync_ok), m_ok);
            chk("R3 R4 R6 R7 sync_error", int'(sync_error), m_err);
            chk("R5 bit_period", int'(bit_period), m_per);
            chk("R8 no_bus_activity", int'(no_bus_activity), m_nba);
            chk("R9 exclusive pulses", int'(sync_ok && sync_error), 0);
            if (sync_ok) cnt_ok++;
            if (sync_error) cnt_err++;
            if (no_bus_activity) cnt_nba++;
        end
    end

    task automatic hold(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_byte(input int bl);
        hold(1'b0, bl);
        for (int i = 0; i < 8; i++) hold(SYNC_PAT[i], bl);
        hold(1'b1, bl);
    endtask

    task automatic header(input int brk, input int gap, input int bl);
        hold(1'b0, brk);
        hold(1'b1, gap);
        sync_byte(bl);
        hold(1'b1, 40);
    endtask

    task automatic clr();
        cnt_ok = 0; cnt_err = 0; cnt_nba = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 sync_ok in reset", int'(sync_ok), 0);
        chk("R1 sync_error in reset", int'(sync_error), 0);
        chk("R1 bit_period in reset", int'(bit_period), 0);
        chk("R1 no_bus_activity in reset", int'(no_bus_activity), 0);
        rst_n = 1'b1; live = 1;
        @(negedge clk);
        chk("R1 outputs after reset", int'({sync_ok, sync_error, no_bus_activity}), 0);

        hold(1'b1, IDLE_T + 5);
        chk("R8 idle flag raised", int'(no_bus_activity), 1);

        clr(); header(180, 20, 16);
        chk("R5 period nominal", int'(bit_period), 16);
        chk("R2 break accepted", cnt_ok, 1);
        chk("R8 flag cleared by break", int'(no_bus_activity), 0);

        clr(); hold(1'b0, 170); hold(1'b1, 60);
        chk("R2 short pulse no ok", cnt_ok, 0);
        chk("R2 short pulse no error", cnt_err, 0);

        clr(); header(BRK_T, NOM, 16);
        chk("R2 R3 minimum break and gap", cnt_ok, 1);

        clr(); header(180, 20, 14);
        chk("R5 period fast", int'(bit_period), 14);
        clr(); header(180, 20, 18);
        chk("R5 period slow", int'(bit_period), 18);

        clr(); header(180, 20, 13);
        chk("R6 rate too fast error", cnt_err, 1);
        chk("R6 rate too fast no ok", cnt_ok, 0);
        chk("R6 period kept", int'(bit_period), 18);

        clr(); hold(1'b0, 180); hold(1'b1, 20); hold(1'b0, 16); hold(1'b1, 200);
        chk("R7 sync byte timeout", cnt_err, 1);

        clr(); hold(1'b0, 180); hold(1'b1, 10); header(180, 20, 16);
        chk("R3 short gap error", cnt_err, 1);
        chk("R3 restart keeps header", cnt_ok, 1);

        clr(); hold(1'b0, 180); hold(1'b1, 300); hold(1'b1, 40);
        chk("R4 long gap error", cnt_err, 1);
        chk("R4 long gap no ok", cnt_ok, 0);

        clr(); hold(1'b0, 5000);
        chk("R8 flag during long dominant", int'(no_bus_activity), 1);
        hold(1'b0, 60600); hold(1'b1, 20); sync_byte(16); hold(1'b1, 40);
        chk("R10 wrapped break accepted", cnt_ok, 1);
        chk("R8 flag cleared after long break", int'(no_bus_activity), 0);

        clr();
        while (quiet != IDLE_T - 181) @(negedge clk);
        header(180, 20, 16);
        chk("R8 clear wins over expiry", cnt_nba, 0);
        chk("R8 header after coincidence", cnt_ok, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule